// File: doc/BRIEF.md
# Gradient Orientation Quantizer

The block takes the signed horizontal and vertical gradients of one pixel and returns a 3-bit code naming one of eight orientations. Code k stands for the direction k times 22.5 degrees, taken over a half turn of 0 to 180 degrees, so a gradient and its negation get the same code. The block never forms an angle and has no divider and no arctangent table. It folds both gradients to magnitudes, swaps them so the working point lies in the lower octant, and then runs two tangent-threshold comparisons. One shared shift-and-add accumulator evaluates both comparisons over a fixed six-step schedule. A small combinational decode then turns the two comparison bits, the swap flag and the quadrant sign into the code.

A caller pulses `start` for one cycle with the gradients on `grad_x` and `grad_y`. The code appears on `dir_code` together with a one-cycle `done` pulse seven clock edges later. It appears one edge later when both gradients are zero. While a computation is in flight, further start pulses are ignored.

Top module: `orient_quant`

## Requirements
- R1: After reset, `done` is 0 and `dir_code` is 0.
- R2: For non-negative gradients, let p = max(|gx|,|gy|) and q = min(|gx|,|gy|), with a swap when |gy| > |gx|. The band is 2 if 64q >= 44p, else 1 if 64q >= 13p, else 0. The code is the band without a swap and 4 minus the band with a swap.
- R3: When exactly one of gx, gy is negative, the code is (8 - e) mod 8, where e is the value from R2 computed on the magnitudes. When both are negative, the code equals e.
- R4: A ratio that lies exactly on a threshold falls into the higher band. When |gx| = |gy| there is no swap, so the code is 2 or 6.
- R5: For non-zero input, `done` rises in the cycle that follows the seventh rising edge, counting the edge that samples `start` as the first.
- R6: `done` is high for exactly one cycle. `dir_code` keeps its value until the next result is delivered.
- R7: A `start` pulse while a computation is in flight has no effect. The running result and its timing are unchanged, and no extra `done` follows.
- R8: When both gradients are zero, `dir_code` is 0 and `done` is high in the cycle that follows the sampling edge.
- R9: The most negative gradient value -2048 is handled as magnitude 2048 on either axis.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request pulse |
| grad_x | input | 12 | Signed horizontal gradient |
| grad_y | input | 12 | Signed vertical gradient |
| dir_code | output | 3 | Orientation code, k x 22.5 degrees |
| done | output | 1 | One-cycle result-valid pulse |

## Verification
Each run is scored by its code and also by its latency, measured in rising edges. A stuck or skipped schedule step therefore shows up as a wrong count at the first `done`, or as no `done` at all. A wrong accumulator sign or decode shows as a wrong code on the very run that caused it, and the directed ratios placed exactly on the 44/64 and 13/64 thresholds make an off-by-one in a comparison visible there. A sequencer that restarts when `start` arrives while busy shows a late `done` or an extra one within eight cycles after the result.

// File: rtl/orient_quant_pkg.sv
package orient_quant_pkg;
  localparam int SH_BASE    = 6;
  localparam int PHASE_W    = 3;
  localparam int LAST_PHASE = 5;
  localparam int HI_PHASE   = 2;

  typedef enum logic {OP_ADD = 1'b0, OP_SUB = 1'b1} op_e;

  typedef struct packed {
    logic       reload;
    op_e        op;
    logic [2:0] shift;
  } step_t;

  // 64q-64p+16p+4p = 64q-44p ; 64q-16p+4p-p = 64q-13p
  function automatic step_t step_of(input logic [PHASE_W-1:0] ph);
    step_t s;
    case (ph)
      3'd0:    s = '{reload: 1'b1, op: OP_SUB, shift: 3'd6};
      3'd1:    s = '{reload: 1'b0, op: OP_ADD, shift: 3'd4};
      3'd2:    s = '{reload: 1'b0, op: OP_ADD, shift: 3'd2};
      3'd3:    s = '{reload: 1'b1, op: OP_SUB, shift: 3'd4};
      3'd4:    s = '{reload: 1'b0, op: OP_ADD, shift: 3'd2};
      default: s = '{reload: 1'b0, op: OP_SUB, shift: 3'd0};
    endcase
    return s;
  endfunction
endpackage

// File: rtl/oq_fold.sv
module oq_fold #(
  parameter int W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic signed [W-1:0] gx,
  input  logic signed [W-1:0] gy,
  output logic [W-1:0]        major,
  output logic [W-1:0]        minor,
  output logic                swapped,
  output logic                neg
);
  logic [W-1:0] ax, ay;

  always_comb begin
    ax = gx[W-1] ? (~gx + 1'b1) : gx;
    ay = gy[W-1] ? (~gy + 1'b1) : gy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      major <= '0; minor <= '0; swapped <= 1'b0; neg <= 1'b0;
    end else if (load) begin
      swapped <= (ay > ax);
      major   <= (ay > ax) ? ay : ax;
      minor   <= (ay > ax) ? ax : ay;
      neg     <= gx[W-1] ^ gy[W-1];
    end
  end

  assert_fold_order_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (major >= minor));
endmodule

// File: rtl/oq_datapath.sv
module oq_datapath
  import orient_quant_pkg::*;
#(
  parameter int W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic [PHASE_W-1:0] phase,
  input  logic [W-1:0]       major,
  input  logic [W-1:0]       minor,
  output logic               hi_dec,
  output logic               sum_nonneg
);
  localparam int ACCW = W + SH_BASE + 2;

  logic signed [ACCW-1:0] acc, opa, opb, sum, ext_major, ext_minor;
  step_t st;

  always_comb begin
    st        = step_of(phase);
    ext_major = signed'({{(ACCW-W){1'b0}}, major});
    ext_minor = signed'({{(ACCW-W){1'b0}}, minor});
    opa       = st.reload ? (ext_minor <<< SH_BASE) : acc;
    opb       = ext_major <<< st.shift;
    sum       = (st.op == OP_SUB) ? (opa - opb) : (opa + opb);
    sum_nonneg = ~sum[ACCW-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      hi_dec <= 1'b0;
    end else if (run) begin
      acc <= sum;
      if (phase == PHASE_W'(HI_PHASE)) hi_dec <= sum_nonneg;
    end
  end

  // a ratio above the upper threshold is also above the lower one
  assert_band_order_R2: assert property (@(posedge clk) disable iff (rst)
    (run && phase == PHASE_W'(LAST_PHASE) && hi_dec) |-> sum_nonneg);
endmodule

// File: rtl/oq_sequencer.sv
module oq_sequencer
  import orient_quant_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               go,
  output logic               run,
  output logic [PHASE_W-1:0] phase
);
  always_ff @(posedge clk) begin
    if (rst) begin
      run   <= 1'b0;
      phase <= '0;
    end else if (go && !run) begin
      run   <= 1'b1;
      phase <= '0;
    end else if (run) begin
      if (phase == PHASE_W'(LAST_PHASE)) begin
        run   <= 1'b0;
        phase <= '0;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  assert_phase_range_R5: assert property (@(posedge clk) disable iff (rst)
    run |-> (phase <= PHASE_W'(LAST_PHASE)));
endmodule

// File: rtl/oq_decode.sv
module oq_decode (
  input  logic       hi,
  input  logic       lo,
  input  logic       swapped,
  input  logic       neg,
  output logic [2:0] code
);
  logic [2:0] band, eff;

  always_comb begin
    band = hi ? 3'd2 : (lo ? 3'd1 : 3'd0);
    eff  = swapped ? (3'd4 - band) : band;
    code = neg ? (3'd0 - eff) : eff;
  end
endmodule

// File: rtl/orient_quant.sv
module orient_quant
  import orient_quant_pkg::*;
#(
  parameter int W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic signed [W-1:0] grad_x,
  input  logic signed [W-1:0] grad_y,
  output logic [2:0]          dir_code,
  output logic                done
);
  logic               run, go, is_zero, hi_dec, sum_nonneg, swapped, neg;
  logic [PHASE_W-1:0] phase;
  logic [W-1:0]       major, minor;
  logic [2:0]         dec_code;

  assign is_zero = (grad_x == '0) && (grad_y == '0);
  assign go      = start && !run && !is_zero;

  oq_fold #(.W(W)) u_fold (
    .clk(clk), .rst(rst), .load(go), .gx(grad_x), .gy(grad_y),
    .major(major), .minor(minor), .swapped(swapped), .neg(neg));

  oq_sequencer u_seq (.clk(clk), .rst(rst), .go(go), .run(run), .phase(phase));

  oq_datapath #(.W(W)) u_dp (
    .clk(clk), .rst(rst), .run(run), .phase(phase), .major(major), .minor(minor),
    .hi_dec(hi_dec), .sum_nonneg(sum_nonneg));

  oq_decode u_dec (.hi(hi_dec), .lo(sum_nonneg), .swapped(swapped), .neg(neg),
    .code(dec_code));

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_code <= 3'd0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !run && is_zero) begin
        dir_code <= 3'd0;
        done     <= 1'b1;
      end else if (run && phase == PHASE_W'(LAST_PHASE)) begin
        dir_code <= dec_code;
        done     <= 1'b1;
      end
    end
  end

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_code_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(dir_code));
  assert_zero_fast_R8: assert property (@(posedge clk) disable iff (rst)
    (start && !run && is_zero) |=> (done && dir_code == 3'd0));
  assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (rst)
    (run && start && phase != PHASE_W'(LAST_PHASE)) |=> (run && phase == $past(phase) + 1'b1));
endmodule

// File: tb/tb_orient_quant.sv
`timescale 1ns/1ps
module tb_orient_quant;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic signed [11:0] grad_x = '0, grad_y = '0;
  logic [2:0] dir_code;
  logic done;
  int checks = 0;
  int errors = 0;

  orient_quant dut (.clk(clk), .rst(rst), .start(start), .grad_x(grad_x),
    .grad_y(grad_y), .dir_code(dir_code), .done(done));

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_code(input int gx, input int gy);
    int ax, ay, p, q, band, e;
    bit sw;
    if (gx == 0 && gy == 0) return 0;
    ax = (gx < 0) ? -gx : gx;
    ay = (gy < 0) ? -gy : gy;
    sw = ay > ax;
    p = sw ? ay : ax;
    q = sw ? ax : ay;
    if (q * 64 >= 44 * p) band = 2;
    else if (q * 64 >= 13 * p) band = 1;
    else band = 0;
    e = sw ? 4 - band : band;
    if ((gx < 0) != (gy < 0)) return (8 - e) % 8;
    return e;
  endfunction

  task automatic run_one(input int gx, input int gy, input string tag);
    int lat, code_o, exp_lat;
    @(negedge clk);
    grad_x = 12'(gx); grad_y = 12'(gy); start = 1'b1;
    @(posedge clk); lat = 1;
    @(negedge clk); start = 1'b0;
    while (!done && lat < 20) begin
      @(posedge clk); lat++;
      @(negedge clk);
    end
    code_o = int'(dir_code);
    exp_lat = (gx == 0 && gy == 0) ? 1 : 7;
    check(lat == exp_lat, (gx == 0 && gy == 0) ? "R8 latency" : "R5 latency", lat, exp_lat);
    check(code_o == exp_code(gx, gy), tag, code_o, exp_code(gx, gy));
    @(negedge clk);
    check(done == 1'b0, "R6 done one cycle", int'(done), 0);
    check(int'(dir_code) == code_o, "R6 code held", int'(dir_code), code_o);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lat, extra;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    check(done == 1'b0, "R1 reset done", int'(done), 0);
    check(dir_code == 3'd0, "R1 reset code", int'(dir_code), 0);

    run_one(100, 0, "R2 horizontal");
    run_one(0, 100, "R2 vertical");
    run_one(100, 30, "R2 low ratio");
    run_one(30, 100, "R2 swapped");
    run_one(100, 100, "R4 diagonal");
    run_one(64, 44, "R4 upper threshold");
    run_one(64, 43, "R4 below upper threshold");
    run_one(64, 13, "R4 lower threshold");
    run_one(64, 12, "R4 below lower threshold");
    run_one(44, 64, "R4 swapped threshold");
    run_one(-100, 100, "R3 opposite signs");
    run_one(100, -30, "R3 opposite signs low");
    run_one(-100, -30, "R3 both negative");
    run_one(-5, 0, "R3 negative x only");
    run_one(0, -5, "R3 negative y only");
    run_one(-2048, -2048, "R9 extreme diagonal");
    run_one(-2048, 0, "R9 extreme x");
    run_one(0, -2048, "R9 extreme y");
    run_one(2047, -2048, "R9 near diagonal");
    run_one(0, 0, "R8 zero code");

    // R7: start pulse while busy
    @(negedge clk);
    grad_x = 12'sd100; grad_y = 12'sd0; start = 1'b1;
    @(posedge clk); lat = 1;
    @(negedge clk); start = 1'b0; grad_x = 12'sd0; grad_y = 12'sd100;
    @(posedge clk); lat++;
    @(negedge clk); start = 1'b1;
    @(posedge clk); lat++;
    @(negedge clk); start = 1'b0;
    while (!done && lat < 20) begin
      @(posedge clk); lat++;
      @(negedge clk);
    end
    check(lat == 7, "R7 busy latency", lat, 7);
    check(dir_code == 3'd0, "R7 busy code", int'(dir_code), 0);
    extra = 0;
    repeat (8) begin
      @(negedge clk);
      if (done) extra++;
    end
    check(extra == 0, "R7 no extra done", extra, 0);

    for (int i = 0; i < 400; i++) begin
      int gx, gy;
      gx = int'($urandom_range(4095)) - 2048;
      gy = int'($urandom_range(4095)) - 2048;
      if (i % 4 == 0) gy = gx * (int'($urandom_range(2)) - 1);
      run_one(gx, gy, "R2 R3 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule